// File: doc/BRIEF.md
# SPI FIFO, Interrupt and DMA Request Unit

This block is the buffering and signalling layer between a simple word-addressed register bus and a SPI shift engine. Software writes words to a transmit data address, and the shift engine drains them in order. The engine deposits received words, and software pops them with reads of a receive data address. Read-only registers report the live fill level of each FIFO. A status word summarises busy, full and empty conditions.

Five interrupt sources are tracked. Two of them follow live FIFO levels against programmable thresholds. The other three are sticky error flags: transmit overflow, receive underflow and receive overflow. Software clears the sticky flags through a dedicated clear register, whose bit layout is not the interrupt layout. A mask register gates the sources onto one interrupt line. Two DMA request lines, each with an enable and a watermark, let a DMA engine keep the FIFOs fed or drained without processor involvement.

The threshold and watermark registers refuse any value at or above the FIFO depth. Software can therefore find the depth by writing growing values and checking the readback.

Top module: `spi_xbuf`

## Requirements
- R1: A bus write to word index 0 appends the low data bits to the transmit FIFO. The engine side sees the oldest word on `tx_data_o`, with `tx_valid_o` high while the FIFO is not empty. A `tx_pop_i` pulse removes that word. Word index 3 reads the transmit level.
- R2: A bus write to index 0 while the transmit FIFO holds DEPTH words is dropped. The level stays the same, and raw interrupt bit 1 (transmit overflow) is set and stays set until cleared.
- R3: `rx_push_i` appends `rx_data_i` to the receive FIFO. Each bus read of index 1 returns the oldest word and removes it. Index 4 reads the receive level.
- R4: A read of index 1 while the receive FIFO is empty returns 0 and leaves the level at 0. It sets sticky raw interrupt bit 2 (receive underflow).
- R5: An `rx_push_i` while the receive FIFO is full is dropped and sets sticky raw interrupt bit 3 (receive overflow).
- R6: The status word at index 2 has these bits: bit 0 busy (`eng_busy_i`, or the transmit FIFO is not empty), bit 1 transmit full, bit 2 transmit empty, bit 3 receive empty, bit 4 receive full.
- R7: The transmit threshold (index 5) and the receive threshold (index 6) store a written value only if it is below DEPTH. Otherwise the old value is kept and reads back.
- R8: Raw interrupt bit 0 is high while the transmit level is at or below the transmit threshold. Raw bit 4 is high while the receive level is above the receive threshold.
- R9: A write to the clear register (index 10) clears sticky flags as follows: data bit 0 clears all of them, bit 1 clears receive underflow, bit 2 clears receive overflow, bit 3 clears transmit overflow. The raw flags read at index 8.
- R10: The mask register (index 7) holds 5 bits. The masked status at index 9 is the raw flags ANDed with the mask, and `irq_o` is the OR of the masked status.
- R11: In the DMA control register (index 11), bit 0 enables receive requests and bit 1 enables transmit requests. `dma_tx_req_o` is high while enabled and the transmit level is at or below the transmit watermark (index 12). `dma_rx_req_o` is high while enabled and the receive level exceeds the receive watermark (index 13). A watermark write of DEPTH or more is ignored.
- R12: After reset, both FIFOs are empty, and all thresholds, watermarks, mask, DMA control and sticky flags are 0. So status reads 0x0C, raw reads 0x01, and `irq_o` and both DMA requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address (combinational) |
| tx_valid_o | output | 1 | Transmit FIFO not empty |
| tx_data_o | output | DW | Oldest transmit word |
| tx_pop_i | input | 1 | Engine consumes transmit word |
| rx_push_i | input | 1 | Engine delivers a received word |
| rx_data_i | input | DW | Received word |
| eng_busy_i | input | 1 | Shift engine is mid-transfer |
| irq_o | output | 1 | Combined masked interrupt |
| dma_tx_req_o | output | 1 | Transmit DMA request |
| dma_rx_req_o | output | 1 | Receive DMA request |

## Verification
The bench builds the block with DEPTH = 8, DW = 16 and AW = 4. At this depth, overfilling either FIFO takes a few accesses, and every threshold rejection boundary (7 kept, 8 refused) can be reached. A 16-bit data width lets distinct word patterns prove ordering through wraparound of both FIFO pointers. A transmit scoreboard and a receive scoreboard check every word that crosses the block. Dropped overflow words must never appear at the other side.

// File: rtl/spi_xbuf_pkg.sv
package spi_xbuf_pkg;
  // register word indices
  localparam int A_TXD    = 0;
  localparam int A_RXD    = 1;
  localparam int A_STAT   = 2;
  localparam int A_TXLVL  = 3;
  localparam int A_RXLVL  = 4;
  localparam int A_TXTHR  = 5;
  localparam int A_RXTHR  = 6;
  localparam int A_MASK   = 7;
  localparam int A_RAW    = 8;
  localparam int A_ISTAT  = 9;
  localparam int A_CLR    = 10;
  localparam int A_DMACTL = 11;
  localparam int A_TXWM   = 12;
  localparam int A_RXWM   = 13;
  // interrupt bit positions
  localparam int I_TXE = 0;
  localparam int I_TXO = 1;
  localparam int I_RXU = 2;
  localparam int I_RXO = 3;
  localparam int I_RXF = 4;
  localparam int NINT  = 5;
endpackage

// File: rtl/spi_xbuf_fifo.sv
module spi_xbuf_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [LW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];
  assign level_o = cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + LW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - LW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end
endmodule

// File: rtl/spi_xbuf_irq.sv
module spi_xbuf_irq
  import spi_xbuf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            live_txe_i,
  input  logic            live_rxf_i,
  input  logic            set_txo_i,
  input  logic            set_rxu_i,
  input  logic            set_rxo_i,
  input  logic            clr_we_i,
  input  logic [3:0]      clr_d_i,
  input  logic            mask_we_i,
  input  logic [NINT-1:0] mask_d_i,
  output logic [NINT-1:0] raw_o,
  output logic [NINT-1:0] mask_o,
  output logic [NINT-1:0] stat_o,
  output logic            irq_o
);
  logic txo_q, rxu_q, rxo_q;
  logic clr_txo, clr_rxu, clr_rxo;

  // clear layout: 0 all, 1 rx underflow, 2 rx overflow, 3 tx overflow
  assign clr_txo = clr_we_i && (clr_d_i[0] || clr_d_i[3]);
  assign clr_rxu = clr_we_i && (clr_d_i[0] || clr_d_i[1]);
  assign clr_rxo = clr_we_i && (clr_d_i[0] || clr_d_i[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txo_q  <= 1'b0;
      rxu_q  <= 1'b0;
      rxo_q  <= 1'b0;
      mask_o <= '0;
    end else begin
      // a new event in the clear cycle wins
      txo_q <= set_txo_i || (txo_q && !clr_txo);
      rxu_q <= set_rxu_i || (rxu_q && !clr_rxu);
      rxo_q <= set_rxo_i || (rxo_q && !clr_rxo);
      if (mask_we_i) mask_o <= mask_d_i;
    end
  end

  always_comb begin
    raw_o        = '0;
    raw_o[I_TXE] = live_txe_i;
    raw_o[I_TXO] = txo_q;
    raw_o[I_RXU] = rxu_q;
    raw_o[I_RXO] = rxo_q;
    raw_o[I_RXF] = live_rxf_i;
  end

  assign stat_o = raw_o & mask_o;
  assign irq_o  = |stat_o;
endmodule

// File: rtl/spi_xbuf_dma.sv
module spi_xbuf_dma #(
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic          txwm_we_i,
  input  logic          rxwm_we_i,
  input  logic [31:0]   wdata_i,
  input  logic [LW-1:0] tx_level_i,
  input  logic [LW-1:0] rx_level_i,
  output logic [1:0]    ctl_o,
  output logic [TW-1:0] tx_wm_o,
  output logic [TW-1:0] rx_wm_o,
  output logic          tx_req_o,
  output logic          rx_req_o
);
  logic fits;
  assign fits = (wdata_i < 32'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o   <= '0;
      tx_wm_o <= '0;
      rx_wm_o <= '0;
    end else begin
      if (ctl_we_i)          ctl_o   <= wdata_i[1:0];
      if (txwm_we_i && fits) tx_wm_o <= wdata_i[TW-1:0];
      if (rxwm_we_i && fits) rx_wm_o <= wdata_i[TW-1:0];
    end
  end

  assign tx_req_o = ctl_o[1] && (tx_level_i <= LW'(tx_wm_o));
  assign rx_req_o = ctl_o[0] && (rx_level_i >  LW'(rx_wm_o));
endmodule

// File: rtl/spi_xbuf.sv
module spi_xbuf
  import spi_xbuf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_pop_i,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          eng_busy_i,
  output logic          irq_o,
  output logic          dma_tx_req_o,
  output logic          dma_rx_req_o
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic wr, rd;
  logic [LW-1:0] tx_level, rx_level;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0] rx_rdata;
  logic tx_push, rx_pop;
  logic [TW-1:0] tx_thr_q, rx_thr_q;
  logic [NINT-1:0] int_raw, int_mask, int_stat;
  logic [1:0] dma_ctl;
  logic [TW-1:0] tx_wm, rx_wm;

  function automatic logic hit(input logic [AW-1:0] a, input int idx);
    return a == AW'(idx);
  endfunction

  assign wr = bus_req_i && bus_we_i;
  assign rd = bus_req_i && !bus_we_i;
  assign tx_push = wr && hit(bus_addr_i, A_TXD);
  assign rx_pop  = rd && hit(bus_addr_i, A_RXD);

  spi_xbuf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txf (
    .clk_i, .rst_ni,
    .push_i (tx_push), .wdata_i(bus_wdata_i[DW-1:0]),
    .pop_i  (tx_pop_i), .rdata_o(tx_data_o),
    .level_o(tx_level), .full_o(tx_full), .empty_o(tx_empty)
  );

  spi_xbuf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxf (
    .clk_i, .rst_ni,
    .push_i (rx_push_i), .wdata_i(rx_data_i),
    .pop_i  (rx_pop), .rdata_o(rx_rdata),
    .level_o(rx_level), .full_o(rx_full), .empty_o(rx_empty)
  );

  assign tx_valid_o = !tx_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else if (wr && bus_wdata_i < 32'(DEPTH)) begin
      // out-of-range thresholds are refused so depth is discoverable
      if (hit(bus_addr_i, A_TXTHR)) tx_thr_q <= bus_wdata_i[TW-1:0];
      if (hit(bus_addr_i, A_RXTHR)) rx_thr_q <= bus_wdata_i[TW-1:0];
    end
  end

  spi_xbuf_irq u_irq (
    .clk_i, .rst_ni,
    .live_txe_i(tx_level <= LW'(tx_thr_q)),
    .live_rxf_i(rx_level >  LW'(rx_thr_q)),
    .set_txo_i (tx_push && tx_full),
    .set_rxu_i (rx_pop && rx_empty),
    .set_rxo_i (rx_push_i && rx_full),
    .clr_we_i  (wr && hit(bus_addr_i, A_CLR)),
    .clr_d_i   (bus_wdata_i[3:0]),
    .mask_we_i (wr && hit(bus_addr_i, A_MASK)),
    .mask_d_i  (bus_wdata_i[NINT-1:0]),
    .raw_o     (int_raw),
    .mask_o    (int_mask),
    .stat_o    (int_stat),
    .irq_o     (irq_o)
  );

  spi_xbuf_dma #(.DEPTH(DEPTH)) u_dma (
    .clk_i, .rst_ni,
    .ctl_we_i  (wr && hit(bus_addr_i, A_DMACTL)),
    .txwm_we_i (wr && hit(bus_addr_i, A_TXWM)),
    .rxwm_we_i (wr && hit(bus_addr_i, A_RXWM)),
    .wdata_i   (bus_wdata_i),
    .tx_level_i(tx_level),
    .rx_level_i(rx_level),
    .ctl_o     (dma_ctl),
    .tx_wm_o   (tx_wm),
    .rx_wm_o   (rx_wm),
    .tx_req_o  (dma_tx_req_o),
    .rx_req_o  (dma_rx_req_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (int'(bus_addr_i))
      A_RXD:    bus_rdata_o = rx_empty ? '0 : 32'(rx_rdata);
      A_STAT:   bus_rdata_o = {27'd0, rx_full, rx_empty, tx_empty, tx_full,
                               eng_busy_i || !tx_empty};
      A_TXLVL:  bus_rdata_o = 32'(tx_level);
      A_RXLVL:  bus_rdata_o = 32'(rx_level);
      A_TXTHR:  bus_rdata_o = 32'(tx_thr_q);
      A_RXTHR:  bus_rdata_o = 32'(rx_thr_q);
      A_MASK:   bus_rdata_o = 32'(int_mask);
      A_RAW:    bus_rdata_o = 32'(int_raw);
      A_ISTAT:  bus_rdata_o = 32'(int_stat);
      A_DMACTL: bus_rdata_o = 32'(dma_ctl);
      A_TXWM:   bus_rdata_o = 32'(tx_wm);
      A_RXWM:   bus_rdata_o = 32'(rx_wm);
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_xbuf_chk.sv
module spi_xbuf_chk
  import spi_xbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_i,
  input logic          bus_we_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [31:0]   bus_wdata_i,
  input logic          tx_pop_i,
  input logic          rx_push_i,
  input logic          tx_valid_o,
  input logic          dma_rx_req_o,
  input logic [NINT-1:0] int_raw,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level
);
  logic bus_tx_wr, bus_rx_rd, clr_all, quiet;
  assign bus_tx_wr = bus_req_i && bus_we_i && bus_addr_i == AW'(A_TXD);
  assign bus_rx_rd = bus_req_i && !bus_we_i && bus_addr_i == AW'(A_RXD);
  assign clr_all   = bus_req_i && bus_we_i && bus_addr_i == AW'(A_CLR) && bus_wdata_i[0];
  assign quiet     = !bus_tx_wr && !bus_rx_rd && !rx_push_i;

  // R1
  tx_valid_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o == (tx_level != '0));
  // R2
  tx_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_tx_wr && tx_level == LW'(DEPTH) && !tx_pop_i) |=> (int_raw[I_TXO] && $stable(tx_level)));
  // R4
  rx_udf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rx_rd && rx_level == '0 && !rx_push_i) |=> (int_raw[I_RXU] && rx_level == '0));
  // R5
  rx_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_level == LW'(DEPTH)) |=> int_raw[I_RXO]);
  // R8
  rx_full_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level == '0) |-> !int_raw[I_RXF]);
  // R9
  clr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all && quiet) |=> (int_raw[3:1] == 3'b000));
  // R11
  dma_rx_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_rx_req_o |-> (rx_level != '0));
endmodule

bind spi_xbuf spi_xbuf_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .tx_pop_i(tx_pop_i),
  .rx_push_i(rx_push_i), .tx_valid_o(tx_valid_o), .dma_rx_req_o(dma_rx_req_o),
  .int_raw(int_raw), .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/spi_xbuf_bench.sv
`timescale 1ns/1ps
module spi_xbuf_bench;
  localparam int DW = 16, DEPTH = 8, AW = 4;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_valid, tx_pop = 0, rx_push = 0, eng_busy = 0;
  logic [DW-1:0] tx_data, rx_data = '0;
  logic irq, dtx, drx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] txq[$], rxq[$];
  int tx_m = 0, rx_m = 0;

  always #2.5 clk = ~clk;

  spi_xbuf #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_spi_xbuf (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_pop_i(tx_pop),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .eng_busy_i(eng_busy),
    .irq_o(irq), .dma_tx_req_o(dtx), .dma_rx_req_o(drx));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = AW'(a);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic rd_chk(string tag, int a, logic [31:0] exp, logic [31:0] msk = 32'hffff_ffff);
    logic [31:0] v;
    bus_rd(a, v);
    chk(tag, v & msk, exp);
  endtask

  // driver: transmit word, scoreboard records only accepted words
  task automatic tx_send(logic [DW-1:0] d);
    if (tx_m < DEPTH) begin txq.push_back(d); tx_m++; end
    bus_wr(0, 32'(d));
  endtask

  // monitor: engine takes one word and compares against scoreboard
  task automatic tx_take(string tag);
    logic [DW-1:0] e;
    @(negedge clk);
    e = txq.pop_front(); tx_m--;
    chk(tag, 32'(tx_data), 32'(e));
    chk(tag, 32'(tx_valid), 1);
    tx_pop = 1;
    @(negedge clk);
    tx_pop = 0;
  endtask

  task automatic rx_deliver(logic [DW-1:0] d);
    if (rx_m < DEPTH) begin rxq.push_back(d); rx_m++; end
    @(negedge clk);
    rx_push = 1; rx_data = d;
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic rx_collect(string tag);
    logic [31:0] v;
    bus_rd(1, v);
    rx_m--;
    chk(tag, v, 32'(rxq.pop_front()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    rd_chk("R12 status", 2, 32'h0C);
    rd_chk("R12 raw", 8, 32'h01);
    chk("R12 irq", 32'(irq), 0);
    chk("R12 dma", 32'({dtx, drx}), 0);
    rd_chk("R12 txlvl", 3, 0);
    // R1 order and level
    tx_send(16'hA001); tx_send(16'hA002); tx_send(16'hA003);
    rd_chk("R1 txlvl", 3, 3);
    rd_chk("R6 status busy+rxempty", 2, 32'h09);
    for (int i = 0; i < 3; i++) tx_take("R1 tx order");
    rd_chk("R1 txlvl drained", 3, 0);
    // R6 busy from engine
    eng_busy = 1;
    rd_chk("R6 status engine busy", 2, 32'h0D);
    eng_busy = 0;
    // R2 overflow
    for (int i = 0; i < 9; i++) tx_send(16'hB000 + 16'(i));
    rd_chk("R2 txlvl full", 3, 8);
    rd_chk("R6 status full", 2, 32'h0B);
    rd_chk("R2 raw txo", 8, 32'h02);
    for (int i = 0; i < 8; i++) tx_take("R2 tx after drop");
    chk("R2 no extra word", 32'(tx_valid), 0);
    // R9 clear tx overflow via bit 3
    bus_wr(10, 32'h8);
    rd_chk("R9 clr txo", 8, 32'h01);
    // R7 threshold rejection
    bus_wr(5, 8);  rd_chk("R7 txthr reject 8", 5, 0);
    bus_wr(5, 7);  rd_chk("R7 txthr keep 7", 5, 7);
    bus_wr(5, 9);  rd_chk("R7 txthr reject 9", 5, 7);
    bus_wr(5, 3);
    bus_wr(6, 8);  rd_chk("R7 rxthr reject", 6, 0);
    bus_wr(6, 2);  rd_chk("R7 rxthr keep", 6, 2);
    // R8 tx level vs threshold
    for (int i = 0; i < 4; i++) tx_send(16'hC000 + 16'(i));
    rd_chk("R8 txe above thr", 8, 0, 32'h01);
    tx_take("R8 tx");
    rd_chk("R8 txe at thr", 8, 1, 32'h01);
    for (int i = 0; i < 3; i++) tx_take("R8 tx");
    // R3 receive path, R8 rx full
    rx_deliver(16'h5A01); rx_deliver(16'h5A02); rx_deliver(16'h5A03);
    rd_chk("R3 rxlvl", 4, 3);
    rd_chk("R8 rxf above thr", 8, 32'h10, 32'h10);
    rx_collect("R3 rx order");
    rd_chk("R8 rxf at thr", 8, 0, 32'h10);
    rx_collect("R3 rx order"); rx_collect("R3 rx order");
    rd_chk("R3 rxlvl drained", 4, 0);
    // R4 underflow
    rd_chk("R4 empty read", 1, 0);
    rd_chk("R4 raw rxu", 8, 32'h04, 32'h0E);
    rd_chk("R4 rxlvl", 4, 0);
    // R5 rx overflow, wrap
    for (int i = 0; i < 9; i++) rx_deliver(16'hD000 + 16'(i));
    rd_chk("R5 rxlvl", 4, 8);
    rd_chk("R6 status rxfull", 2, 32'h14);
    rd_chk("R5 raw rxo", 8, 32'h0C, 32'h0E);
    for (int i = 0; i < 8; i++) rx_collect("R5 rx after drop");
    rd_chk("R5 rx empty after", 1, 0);
    // R9 selective then all
    bus_wr(10, 32'h2);
    rd_chk("R9 clr rxu only", 8, 32'h08, 32'h0E);
    bus_wr(10, 32'h1);
    rd_chk("R9 clr all", 8, 0, 32'h0E);
    // R10 mask
    chk("R10 irq masked", 32'(irq), 0);
    bus_wr(7, 32'h01);
    chk("R10 irq on", 32'(irq), 1);
    rd_chk("R10 istat", 9, 32'h01);
    rd_chk("R10 mask rb", 7, 32'h01);
    bus_wr(7, 32'h10);
    chk("R10 irq off", 32'(irq), 0);
    rd_chk("R10 istat off", 9, 0);
    // R11 dma
    bus_wr(12, 2);
    chk("R11 tx disabled", 32'(dtx), 0);
    bus_wr(11, 2);
    chk("R11 tx req low level", 32'(dtx), 1);
    for (int i = 0; i < 3; i++) tx_send(16'hE000 + 16'(i));
    chk("R11 tx req above wm", 32'(dtx), 0);
    bus_wr(12, 8);
    rd_chk("R11 wm reject", 12, 2);
    bus_wr(13, 1); bus_wr(11, 3);
    chk("R11 rx none", 32'(drx), 0);
    rx_deliver(16'h0F01);
    chk("R11 rx at wm", 32'(drx), 0);
    rx_deliver(16'h0F02);
    chk("R11 rx above wm", 32'(drx), 1);
    bus_wr(11, 1);
    chk("R11 tx en off", 32'(dtx), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule